// File: doc/BRIEF.md
# Processor Subsystem Reset Sequencer

This block is the state machine inside a power and reset controller that takes a processor subsystem out of reset in a fixed order. After power-on reset it first frees the always-on interrupt controller. It then waits until the subsystem PLL reports a running clock, and only then frees the subsystem power-on reset together with the memory-adapter resets. Next it waits for the subsystem to report that its internal reset has finished, frees the main processor reset, and finally lowers the L2 reset-disable control after a fixed delay.

The L2 reset-disable control depends on the wakeup type. On a cold wakeup from OFF, and on a warm reset, the L2 cache is reset and the control is lowered after the delay. On a wakeup from retention the control stays high for the whole sequence, so the cache contents are kept. A warm-reset request from the controller starts the sequence again from the all-asserted state in any state, and the next sequence always resets L2. The PLL clock-active and reset-done inputs are asynchronous and pass through synchronizers. All outputs are registered. The L1 cache has no retention path, so it is reset on every wakeup.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: While `rst` is high, every reset output and `l2_rst_dis_o` are 1 on the edge after `rst` is sampled.
- R2: The interrupt-controller reset `intc_rst_o` falls on the first clock edge after `rst` is sampled low. No other output is released before it.
- R3: `pwron_rst_o` and all `ma_rst_o` bits fall together on the third clock edge after `pll_ok_i` rises while the block is waiting for the clock. They are still 1 on the second edge.
- R4: While `pll_ok_i` stays low, `pwron_rst_o` stays 1, whatever `rst_done_i` does.
- R5: `cpu_rst_o` falls on the third edge after `rst_done_i` rises while the block is waiting for it. If `rst_done_i` is already high and synchronized, `cpu_rst_o` falls on the edge after `pwron_rst_o` falls.
- R6: With wake code 00 (cold from OFF), `l2_rst_dis_o` falls exactly 32 edges after the edge where `cpu_rst_o` falls, and is still 1 on the 31st.
- R7: With wake code 10 (wakeup from retention), `l2_rst_dis_o` stays 1 for the whole sequence and afterwards.
- R8: Once low, `l2_rst_dis_o` stays low until the next transition. A high `warm_req_i` sets every output to 1 on the next edge, from any state.
- R9: The sequence that follows a warm-reset request resets L2, so `l2_rst_dis_o` falls as in R6 even when the wake code is 10.
- R10: Wake code 01 (warm) and code 11 behave like code 00 for `l2_rst_dis_o`.
- R11: The wake code is sampled once, on the edge where `intc_rst_o` is released. Later changes have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| warm_req_i | input | 1 | Warm reset request, synchronous, one or more cycles |
| pll_ok_i | input | 1 | PLL clock-active indication, asynchronous |
| rst_done_i | input | 1 | Subsystem internal reset complete, asynchronous |
| wake_kind_i | input | 2 | Wakeup type: 00 cold, 01 warm, 10 retention, 11 as cold |
| intc_rst_o | output | 1 | Always-on interrupt controller reset, active high |
| pwron_rst_o | output | 1 | Subsystem power-on reset, active high |
| ma_rst_o | output | NUM_MA | Memory-adapter resets, active high |
| cpu_rst_o | output | 1 | Main processor reset, active high |
| l2_rst_dis_o | output | 1 | L2 reset-disable control; high keeps L2 out of reset |

## Verification
Each result has a fixed due edge. The interrupt-controller release comes on the first edge after reset. The power-on and adapter releases come on the third edge after the clock-active input rises, because of two synchronizer flops and the state register. The processor release also comes on the third edge after reset-done, or on the very next edge when reset-done was already high. The L2 control falls 32 edges after that. The bench drives every input on a falling edge, then counts rising edges and samples one time unit later. It checks both the edge just before each release and the release edge itself, so a release that comes early or late by one cycle is caught.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_CLK  = 3'd1,
    ST_WAIT_DONE = 3'd2,
    ST_RUN_DELAY = 3'd3,
    ST_RUN       = 3'd4
  } seq_state_t;

  localparam logic [1:0] WAKE_COLD = 2'b00;
  localparam logic [1:0] WAKE_WARM = 2'b01;
  localparam logic [1:0] WAKE_RET  = 2'b10;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay #(
  parameter int DLY = 32,
  localparam int W = $clog2(DLY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  logic [W-1:0] cnt;

  assign hit = (cnt == W'(DLY - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)     cnt <= '0;
    else if (en && !hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       warm_req,
  input  logic       clk_ok,
  input  logic       sub_done,
  input  logic [1:0] wake_kind,
  input  logic       dly_hit,
  output logic       dly_clr,
  output logic       dly_en,
  output logic       restart,
  output logic       rel_pwron,
  output logic       intc_rst,
  output logic       pwron_rst,
  output logic       cpu_rst,
  output logic       l2_dis
);
  seq_state_t state;
  logic       keep_l2;
  logic       warm_pend;

  assign restart   = rst | warm_req;
  assign rel_pwron = (state == ST_WAIT_CLK) && clk_ok && !restart;
  assign dly_clr   = (state == ST_WAIT_DONE) && sub_done;
  assign dly_en    = (state == ST_RUN_DELAY);

  always_ff @(posedge clk) begin
    if (restart) begin
      state     <= ST_IDLE;
      intc_rst  <= 1'b1;
      pwron_rst <= 1'b1;
      cpu_rst   <= 1'b1;
      l2_dis    <= 1'b1;
      keep_l2   <= 1'b0;
      warm_pend <= warm_req;
    end else begin
      case (state)
        ST_IDLE: begin
          intc_rst  <= 1'b0;
          keep_l2   <= (wake_kind == WAKE_RET) && !warm_pend;
          warm_pend <= 1'b0;
          state     <= ST_WAIT_CLK;
        end
        ST_WAIT_CLK: begin
          if (clk_ok) begin
            pwron_rst <= 1'b0;
            state     <= ST_WAIT_DONE;
          end
        end
        ST_WAIT_DONE: begin
          if (sub_done) begin
            cpu_rst <= 1'b0;
            state   <= ST_RUN_DELAY;
          end
        end
        ST_RUN_DELAY: begin
          if (dly_hit) begin
            l2_dis <= keep_l2;
            state  <= ST_RUN;
          end
        end
        ST_RUN: state <= ST_RUN;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpu_reset_sequencer.sv
module cpu_reset_sequencer #(
  parameter int NUM_MA      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int L2_DELAY    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_req_i,
  input  logic              pll_ok_i,
  input  logic              rst_done_i,
  input  logic [1:0]        wake_kind_i,
  output logic              intc_rst_o,
  output logic              pwron_rst_o,
  output logic [NUM_MA-1:0] ma_rst_o,
  output logic              cpu_rst_o,
  output logic              l2_rst_dis_o
);
  logic clk_ok_s, done_s, done_sync_rst;
  logic dly_hit, dly_clr, dly_en, restart, rel_pwron;

  assign done_sync_rst = rst | warm_req_i;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_pll_sync (
    .clk(clk), .rst(rst), .d(pll_ok_i), .q(clk_ok_s)
  );

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk), .rst(done_sync_rst), .d(rst_done_i), .q(done_s)
  );

  rstseq_delay #(.DLY(L2_DELAY)) u_delay (
    .clk(clk), .rst(rst), .clr(dly_clr), .en(dly_en), .hit(dly_hit)
  );

  rstseq_fsm u_fsm (
    .clk(clk), .rst(rst), .warm_req(warm_req_i), .clk_ok(clk_ok_s),
    .sub_done(done_s), .wake_kind(wake_kind_i), .dly_hit(dly_hit),
    .dly_clr(dly_clr), .dly_en(dly_en), .restart(restart),
    .rel_pwron(rel_pwron), .intc_rst(intc_rst_o), .pwron_rst(pwron_rst_o),
    .cpu_rst(cpu_rst_o), .l2_dis(l2_rst_dis_o)
  );

  for (genvar i = 0; i < NUM_MA; i++) begin : g_ma
    always_ff @(posedge clk) begin
      if (restart)        ma_rst_o[i] <= 1'b1;
      else if (rel_pwron) ma_rst_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cpu_reset_sequencer_chk.sv
module cpu_reset_sequencer_chk #(
  parameter int NUM_MA = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              warm_req_i,
  input logic              pll_ok_i,
  input logic              rst_done_i,
  input logic              intc_rst_o,
  input logic              pwron_rst_o,
  input logic [NUM_MA-1:0] ma_rst_o,
  input logic              cpu_rst_o,
  input logic              l2_rst_dis_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (intc_rst_o && pwron_rst_o && (&ma_rst_o) && cpu_rst_o && l2_rst_dis_o));

  // R2
  intc_first_chk: assert property (@(posedge clk) disable iff (rst)
    !pwron_rst_o |-> !intc_rst_o);

  // R3
  ma_with_pwron_chk: assert property (@(posedge clk) disable iff (rst)
    ma_rst_o == {NUM_MA{pwron_rst_o}});

  // R4
  pll_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwron_rst_o) |-> $past(pll_ok_i, 2));

  // R5
  cpu_order_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rst_o |-> !pwron_rst_o);

  // R5
  cpu_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rst_o) |-> $past(rst_done_i, 2));

  // R6
  l2_order_chk: assert property (@(posedge clk) disable iff (rst)
    !l2_rst_dis_o |-> !cpu_rst_o);

  // R8
  l2_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!l2_rst_dis_o && !warm_req_i) |=> !l2_rst_dis_o);

  // R8
  warm_restart_chk: assert property (@(posedge clk) disable iff (rst)
    warm_req_i |=> (intc_rst_o && pwron_rst_o && (&ma_rst_o) && cpu_rst_o && l2_rst_dis_o));
endmodule

bind cpu_reset_sequencer cpu_reset_sequencer_chk #(.NUM_MA(NUM_MA)) u_chk (
  .clk(clk), .rst(rst), .warm_req_i(warm_req_i), .pll_ok_i(pll_ok_i),
  .rst_done_i(rst_done_i), .intc_rst_o(intc_rst_o), .pwron_rst_o(pwron_rst_o),
  .ma_rst_o(ma_rst_o), .cpu_rst_o(cpu_rst_o), .l2_rst_dis_o(l2_rst_dis_o)
);

// File: tb/sim_cpu_reset_sequencer.sv
`timescale 1ns/1ps
module sim_cpu_reset_sequencer;
  localparam int NUM_MA = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic warm_req = 1'b0;
  logic pll_ok = 1'b0;
  logic rst_done = 1'b0;
  logic [1:0] wake = 2'b00;
  logic intc_rst, pwron_rst, cpu_rst, l2_dis;
  logic [NUM_MA-1:0] ma_rst;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cpu_reset_sequencer #(.NUM_MA(NUM_MA)) u0 (
    .clk(clk), .rst(rst), .warm_req_i(warm_req), .pll_ok_i(pll_ok),
    .rst_done_i(rst_done), .wake_kind_i(wake), .intc_rst_o(intc_rst),
    .pwron_rst_o(pwron_rst), .ma_rst_o(ma_rst), .cpu_rst_o(cpu_rst),
    .l2_rst_dis_o(l2_dis)
  );

  function automatic logic [6:0] outs();
    return {intc_rst, pwron_rst, ma_rst, cpu_rst, l2_dis};
  endfunction

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [1:0] w, input logic pll, input logic done);
    @(negedge clk);
    rst = 1'b1; wake = w; pll_ok = pll; rst_done = done; warm_req = 1'b0;
    step(3);
    chk("R1 reset state", outs(), 7'h7F);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive done, expect cpu release on the 3rd edge, then L2 at +32
  task automatic done_and_l2(input string tag, input logic expect_l2);
    @(negedge clk);
    rst_done = 1'b1;
    step(2);
    chk({"R5 cpu held before done sync ", tag}, {6'd0, cpu_rst}, 7'd1);
    step(1);
    chk({"R5 cpu released ", tag}, {6'd0, cpu_rst}, 7'd0);
    step(31);
    chk({"R6 l2 high on edge 31 ", tag}, {6'd0, l2_dis}, 7'd1);
    step(1);
    chk({"l2 on edge 32 ", tag}, {6'd0, l2_dis}, {6'd0, expect_l2});
  endtask

  initial begin
    // Scenario A: cold wake, late PLL, late reset-done
    do_reset(2'b00, 1'b0, 1'b0);
    step(1);
    chk("R2 intc released first", outs(), 7'b0_1_111_1_1);
    @(negedge clk) rst_done = 1'b1;
    step(10);
    chk("R4 pwron held without pll", outs(), 7'b0_1_111_1_1);
    @(negedge clk) begin pll_ok = 1'b1; rst_done = 1'b0; end
    step(2);
    chk("R3 pwron not early", outs(), 7'b0_1_111_1_1);
    step(1);
    chk("R3 pwron and ma released", outs(), 7'b0_0_000_1_1);
    step(20);
    chk("R5 cpu waits for done", outs(), 7'b0_0_000_1_1);
    done_and_l2("R6 cold", 1'b0);
    step(50);
    chk("R8 l2 stays low", {6'd0, l2_dis}, 7'd0);
    @(negedge clk) warm_req = 1'b1;
    step(1);
    chk("R8 warm request reasserts all", outs(), 7'h7F);
    @(negedge clk) begin warm_req = 1'b0; rst_done = 1'b0; end

    // Scenario B: retention wake, PLL and done already high
    do_reset(2'b10, 1'b1, 1'b1);
    step(2);
    chk("R3 pwron held on edge 2", {6'd0, pwron_rst}, 7'd1);
    step(1);
    chk("R3 pwron released on edge 3", outs(), 7'b0_0_000_1_1);
    step(1);
    chk("R5 immediate done releases cpu", outs(), 7'b0_0_000_0_1);
    step(100);
    chk("R7 retention keeps l2 high", outs(), 7'b0_0_000_0_1);

    // warm request from RUN with wake still retention -> L2 reset applied
    @(negedge clk) warm_req = 1'b1;
    step(1);
    chk("R8 warm from run", outs(), 7'h7F);
    @(negedge clk) begin warm_req = 1'b0; rst_done = 1'b0; end
    step(1);
    chk("R2 intc after warm", outs(), 7'b0_1_111_1_1);
    step(1);
    chk("R3 pwron after warm", outs(), 7'b0_0_000_1_1);
    done_and_l2("R9 after warm", 1'b0);

    // Scenario C: wake code 01, code changed mid-sequence
    do_reset(2'b01, 1'b1, 1'b0);
    step(1);
    @(negedge clk) wake = 2'b10;
    step(2);
    chk("R11 pwron released", outs(), 7'b0_0_000_1_1);
    done_and_l2("R10 R11 warm code", 1'b0);

    // Scenario D: code 11, warm request while waiting for done
    do_reset(2'b11, 1'b1, 1'b0);
    step(3);
    chk("R3 pwron released D", outs(), 7'b0_0_000_1_1);
    step(2);
    @(negedge clk) warm_req = 1'b1;
    step(1);
    chk("R8 warm during wait", outs(), 7'h7F);
    @(negedge clk) warm_req = 1'b0;
    step(2);
    chk("R3 pwron again", outs(), 7'b0_0_000_1_1);
    done_and_l2("R10 code 11", 1'b0);

    // Scenario E: retention wake, late done, l2 held
    do_reset(2'b10, 1'b1, 1'b0);
    step(3);
    done_and_l2("R7 retention late done", 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule